// File: doc/BRIEF.md
# PIO Drive Timing Count Calculator

This block turns a requested programmed-I/O transfer mode and a total bus cycle time, given in nanoseconds, into the three clock counts that a drive timing generator needs: address setup, strobe active and strobe recovery. The clock period of the timing generator is a build parameter. The minimum setup and active times for each mode sit in a constant table. Every time is turned into clocks by ceiling division. One restoring divider does the four divisions one after another, so the block keeps no combinational divider in its path.

A request is a one-cycle `start` pulse. `busy` is high while the request is computed, and `valid` pulses once when the results are ready. The raw counts for the requesting drive come out, and so do the encoded fields to program. The fields are merged with the partner drive's counts when the two drives share one set of timing registers. The result registers hold their values until the next result.

Top module: `pio_clk_calc`

## Requirements
- R1: A `mode` value above 5 is treated as mode 5. Modes 6 and 7 give the same results as mode 5.
- R2: The cycle, setup, active and recovery counts are each the ceiling of their time divided by `CLK_NS`. Recovery time is the cycle time minus the mode's setup and active times, taken as 0 when that difference is negative. The mode table in ns, as setup/active, is: 0: 70/165, 1: 50/125, 2: 30/100, 3: 30/80, 4: 25/70, 5: 20/50.
- R3: The recovery count is the larger of its own ceiling count and the cycle count minus the setup and active counts, with that difference taken as 0 when negative. The active and recovery counts are each then raised to at least 2.
- R4: After the minimums, a recovery count above 17 is set to 17 and the excess is added to the active count. The active count is then capped at 16.
- R5: When `late_rev` is 1, the recovery count is lowered by 1 after the spill step. In both revisions it is then capped at 16.
- R6: When `mate_present` is 1, each of the setup, active and recovery values used for the encoded fields is the larger of the drive's own count and the matching mate count. When `mate_present` is 0, the own counts are used. `setup_cnt`, `active_cnt` and `recovery_cnt` always carry the drive's own counts.
- R7: `setup_code` is 2'b00 for 4 clocks, 2'b10 for 3 clocks, 2'b01 for 1 or 2 clocks and 2'b11 for any other count. `active_field` and `recovery_field` are the low 4 bits of their counts, so 16 is encoded as 0.
- R8: `start` is accepted only while `busy` is 0, and `busy` rises in the next cycle. A `start` seen while `busy` is 1 is ignored. `valid` is a one-cycle pulse during which `busy` is 0. All result outputs change only in a cycle where `valid` is 1.
- R9: After reset, `busy` and `valid` are 0 and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse |
| mode | input | 3 | Requested PIO mode |
| cycle_ns | input | TIME_W | Total cycle time in ns |
| late_rev | input | 1 | Selects the later revision's recovery offset |
| mate_present | input | 1 | Partner drive shares the timing registers |
| mate_setup | input | CNT_W | Partner setup count |
| mate_active | input | CNT_W | Partner active count |
| mate_recovery | input | CNT_W | Partner recovery count |
| busy | output | 1 | Request in progress |
| valid | output | 1 | Result ready pulse |
| setup_cnt | output | CNT_W | Own setup count |
| active_cnt | output | CNT_W | Own active count |
| recovery_cnt | output | CNT_W | Own recovery count |
| setup_code | output | 2 | Encoded merged setup |
| active_field | output | 4 | Encoded merged active |
| recovery_field | output | 4 | Encoded merged recovery |

## Verification
Two events can fall in the same cycle: a result being presented and a new request arriving. The bench raises `start` in the very cycle in which `valid` is seen. In the following cycle it checks that the request was taken (`busy` high, `valid` low) and that the old result is still held. It then checks that the next result belongs to the new request. A second collision, a `start` issued while the block is busy, is judged by the result: it must match the first request alone.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

    localparam int MODE_TOP = 5;

    typedef enum logic [1:0] {PH_IDLE, PH_DIV, PH_FIN} phase_e;

    // minimum address setup time per mode, ns
    function automatic logic [7:0] setup_ns_of(input logic [2:0] m);
        case (m)
            3'd0:    return 8'd70;
            3'd1:    return 8'd50;
            3'd2:    return 8'd30;
            3'd3:    return 8'd30;
            3'd4:    return 8'd25;
            default: return 8'd20;
        endcase
    endfunction

    // minimum strobe active time per mode, ns
    function automatic logic [7:0] active_ns_of(input logic [2:0] m);
        case (m)
            3'd0:    return 8'd165;
            3'd1:    return 8'd125;
            3'd2:    return 8'd100;
            3'd3:    return 8'd80;
            3'd4:    return 8'd70;
            default: return 8'd50;
        endcase
    endfunction

endpackage

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
    parameter int W       = 16,
    parameter int DIVISOR = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 2);
    localparam logic [W:0] DV   = (W+1)'(DIVISOR);
    localparam logic [W:0] BIAS = (W+1)'(DIVISOR - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic [W:0]    rem;
        logic [W:0]    qv;
        logic          done;
    } div_t;

    div_t q, d;
    logic [W:0] sh;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        sh     = {q.rem[W-1:0], q.qv[W]};
        if (go) begin
            d.run = 1'b1;
            d.cnt = CW'(W + 1);
            d.rem = '0;
            d.qv  = {1'b0, num} + BIAS;   // ceiling via biased dividend
        end else if (q.run) begin
            if (sh >= DV) begin
                d.rem = sh - DV;
                d.qv  = {q.qv[W-1:0], 1'b1};
            end else begin
                d.rem = sh;
                d.qv  = {q.qv[W-1:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign quo  = q.qv[W-1:0];
endmodule

// File: rtl/pio_count_rules.sv
module pio_count_rules #(
    parameter int TIME_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic [TIME_W-1:0] cyc_c,
    input  logic [TIME_W-1:0] su_c,
    input  logic [TIME_W-1:0] ac_c,
    input  logic [TIME_W-1:0] rc_c,
    input  logic              late,
    output logic [CNT_W-1:0]  su_o,
    output logic [CNT_W-1:0]  ac_o,
    output logic [CNT_W-1:0]  rc_o
);
    localparam int XW = TIME_W + 2;
    localparam logic [XW-1:0] SU_MAX = XW'((1 << CNT_W) - 1);

    logic [XW-1:0] used, rec2, r, a;

    always_comb begin
        used = XW'(su_c) + XW'(ac_c);
        rec2 = (XW'(cyc_c) > used) ? XW'(cyc_c) - used : '0;
        r    = (XW'(rc_c) > rec2) ? XW'(rc_c) : rec2;
        if (r < XW'(2)) r = XW'(2);
        a = XW'(ac_c);
        if (a < XW'(2)) a = XW'(2);
        if (r > XW'(17)) begin
            a = a + (r - XW'(17));
            r = XW'(17);
        end
        if (a > XW'(16)) a = XW'(16);
        if (late) r = r - XW'(1);
        if (r > XW'(16)) r = XW'(16);
        su_o = (XW'(su_c) > SU_MAX) ? SU_MAX[CNT_W-1:0] : su_c[CNT_W-1:0];
        ac_o = a[CNT_W-1:0];
        rc_o = r[CNT_W-1:0];
    end
endmodule

// File: rtl/pio_chan_merge.sv
module pio_chan_merge #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] su,
    input  logic [CNT_W-1:0] ac,
    input  logic [CNT_W-1:0] rc,
    input  logic             mpres,
    input  logic [CNT_W-1:0] msu,
    input  logic [CNT_W-1:0] mac,
    input  logic [CNT_W-1:0] mrc,
    output logic [1:0]       code,
    output logic [3:0]       af,
    output logic [3:0]       rf
);
    logic [CNT_W-1:0] ms, ma, mr;

    always_comb begin
        ms = su;
        ma = ac;
        mr = rc;
        if (mpres) begin
            if (msu > ms) ms = msu;
            if (mac > ma) ma = mac;
            if (mrc > mr) mr = mrc;
        end
        if (ms == CNT_W'(4))                           code = 2'b00;
        else if (ms == CNT_W'(3))                      code = 2'b10;
        else if (ms == CNT_W'(1) || ms == CNT_W'(2))   code = 2'b01;
        else                                           code = 2'b11;
        af = ma[3:0];
        rf = mr[3:0];
    end
endmodule

// File: rtl/pio_clk_calc.sv
module pio_clk_calc
    import pio_calc_pkg::*;
#(
    parameter int CLK_NS = 30,
    parameter int TIME_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic [TIME_W-1:0] cycle_ns,
    input  logic              late_rev,
    input  logic              mate_present,
    input  logic [CNT_W-1:0]  mate_setup,
    input  logic [CNT_W-1:0]  mate_active,
    input  logic [CNT_W-1:0]  mate_recovery,
    output logic              busy,
    output logic              valid,
    output logic [CNT_W-1:0]  setup_cnt,
    output logic [CNT_W-1:0]  active_cnt,
    output logic [CNT_W-1:0]  recovery_cnt,
    output logic [1:0]        setup_code,
    output logic [3:0]        active_field,
    output logic [3:0]        recovery_field
);
    typedef struct packed {
        phase_e            ph;
        logic [1:0]        idx;
        logic              go;
        logic [2:0]        mode;
        logic [TIME_W-1:0] cyc_ns;
        logic              late;
        logic              mpres;
        logic [CNT_W-1:0]  msu, mac, mrc;
        logic [TIME_W-1:0] c_cyc, c_su, c_ac, c_rc;
        logic              vld;
        logic [CNT_W-1:0]  su, ac, rc;
        logic [1:0]        code;
        logic [3:0]        af, rf;
    } calc_t;

    calc_t q, d;

    logic [TIME_W:0]   st_at;
    logic [TIME_W-1:0] rec_ns, div_num, div_quo;
    logic              div_done;
    logic [CNT_W-1:0]  r_su, r_ac, r_rc;
    logic [1:0]        m_code;
    logic [3:0]        m_af, m_rf;

    // recovery time, floored at zero
    always_comb begin
        st_at  = (TIME_W+1)'(setup_ns_of(q.mode)) + (TIME_W+1)'(active_ns_of(q.mode));
        rec_ns = ({1'b0, q.cyc_ns} > st_at) ? q.cyc_ns - st_at[TIME_W-1:0] : '0;
        case (q.idx)
            2'd0:    div_num = q.cyc_ns;
            2'd1:    div_num = TIME_W'(setup_ns_of(q.mode));
            2'd2:    div_num = TIME_W'(active_ns_of(q.mode));
            default: div_num = rec_ns;
        endcase
    end

    pio_ceil_div #(.W(TIME_W), .DIVISOR(CLK_NS)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (q.go),
        .num  (div_num),
        .done (div_done),
        .quo  (div_quo)
    );

    pio_count_rules #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_rules (
        .cyc_c(q.c_cyc),
        .su_c (q.c_su),
        .ac_c (q.c_ac),
        .rc_c (q.c_rc),
        .late (q.late),
        .su_o (r_su),
        .ac_o (r_ac),
        .rc_o (r_rc)
    );

    pio_chan_merge #(.CNT_W(CNT_W)) u_merge (
        .su   (r_su),
        .ac   (r_ac),
        .rc   (r_rc),
        .mpres(q.mpres),
        .msu  (q.msu),
        .mac  (q.mac),
        .mrc  (q.mrc),
        .code (m_code),
        .af   (m_af),
        .rf   (m_rf)
    );

    always_comb begin
        d     = q;
        d.go  = 1'b0;
        d.vld = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph     = PH_DIV;
                    d.idx    = 2'd0;
                    d.go     = 1'b1;
                    d.mode   = (mode > 3'(MODE_TOP)) ? 3'(MODE_TOP) : mode;
                    d.cyc_ns = cycle_ns;
                    d.late   = late_rev;
                    d.mpres  = mate_present;
                    d.msu    = mate_setup;
                    d.mac    = mate_active;
                    d.mrc    = mate_recovery;
                end
            end
            PH_DIV: begin
                if (div_done) begin
                    case (q.idx)
                        2'd0:    d.c_cyc = div_quo;
                        2'd1:    d.c_su  = div_quo;
                        2'd2:    d.c_ac  = div_quo;
                        default: d.c_rc  = div_quo;
                    endcase
                    if (q.idx == 2'd3) begin
                        d.ph = PH_FIN;
                    end else begin
                        d.idx = q.idx + 2'd1;
                        d.go  = 1'b1;
                    end
                end
            end
            default: begin
                d.su   = r_su;
                d.ac   = r_ac;
                d.rc   = r_rc;
                d.code = m_code;
                d.af   = m_af;
                d.rf   = m_rf;
                d.vld  = 1'b1;
                d.ph   = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy           = (q.ph != PH_IDLE);
    assign valid          = q.vld;
    assign setup_cnt      = q.su;
    assign active_cnt     = q.ac;
    assign recovery_cnt   = q.rc;
    assign setup_code     = q.code;
    assign active_field   = q.af;
    assign recovery_field = q.rf;
endmodule

// File: rtl/pio_clk_calc_chk.sv
module pio_clk_calc_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             mate_present,
    input logic             busy,
    input logic             valid,
    input logic [CNT_W-1:0] setup_cnt,
    input logic [CNT_W-1:0] active_cnt,
    input logic [CNT_W-1:0] recovery_cnt,
    input logic [1:0]       setup_code,
    input logic [3:0]       active_field,
    input logic [3:0]       recovery_field
);
    logic pres_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pres_q <= 1'b0;
        else if (start && !busy) pres_q <= mate_present;
    end

    a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);
    a_r8_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !busy);
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable({setup_cnt, active_cnt, recovery_cnt,
                            setup_code, active_field, recovery_field}));
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> active_cnt >= CNT_W'(2));
    a_r4_active_cap: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> active_cnt <= CNT_W'(16));
    a_r5_rec_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> recovery_cnt >= CNT_W'(1) && recovery_cnt <= CNT_W'(16));
    a_r6_own_fields: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !pres_q |-> active_field == active_cnt[3:0]
                          && recovery_field == recovery_cnt[3:0]);
    a_r7_short_setup: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !pres_q && (setup_cnt == CNT_W'(1) || setup_cnt == CNT_W'(2))
            |-> setup_code == 2'b01);
endmodule

bind pio_clk_calc pio_clk_calc_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pio_clk_calc_test.sv
module pio_clk_calc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [15:0] cycle_ns = '0;
    logic        late_rev = 1'b0;
    logic        mate_present = 1'b0;
    logic [7:0]  mate_setup = '0, mate_active = '0, mate_recovery = '0;
    logic        busy, valid;
    logic [7:0]  setup_cnt, active_cnt, recovery_cnt;
    logic [1:0]  setup_code;
    logic [3:0]  active_field, recovery_field;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pio_clk_calc uut (.*);

    typedef struct packed {
        logic [23:0] tag;
        logic [2:0]  md;
        logic [15:0] cyc;
        logic        late;
        logic        mp;
        logic [7:0]  msu, mac, mrc;
        logic [7:0]  esu, eac, erc;
        logic [1:0]  ecode;
        logic [3:0]  eaf, erf;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{"R2 ", 3'd0, 16'd600,  1'b0, 1'b0, 8'd0, 8'd0,  8'd0,  8'd3, 8'd6,  8'd13, 2'b10, 4'd6,  4'd13},
        '{"R5 ", 3'd0, 16'd600,  1'b1, 1'b0, 8'd0, 8'd0,  8'd0,  8'd3, 8'd6,  8'd12, 2'b10, 4'd6,  4'd12},
        '{"R3 ", 3'd4, 16'd120,  1'b1, 1'b0, 8'd0, 8'd0,  8'd0,  8'd1, 8'd3,  8'd1,  2'b01, 4'd3,  4'd1},
        '{"R3 ", 3'd5, 16'd100,  1'b0, 1'b0, 8'd0, 8'd0,  8'd0,  8'd1, 8'd2,  8'd2,  2'b01, 4'd2,  4'd2},
        '{"R4 ", 3'd2, 16'd900,  1'b1, 1'b0, 8'd0, 8'd0,  8'd0,  8'd1, 8'd13, 8'd16, 2'b01, 4'd13, 4'd0},
        '{"R5 ", 3'd2, 16'd900,  1'b0, 1'b0, 8'd0, 8'd0,  8'd0,  8'd1, 8'd13, 8'd16, 2'b01, 4'd13, 4'd0},
        '{"R4 ", 3'd3, 16'd1500, 1'b1, 1'b0, 8'd0, 8'd0,  8'd0,  8'd1, 8'd16, 8'd16, 2'b01, 4'd0,  4'd0},
        '{"R2 ", 3'd0, 16'd100,  1'b0, 1'b0, 8'd0, 8'd0,  8'd0,  8'd3, 8'd6,  8'd2,  2'b10, 4'd6,  4'd2},
        '{"R1 ", 3'd7, 16'd120,  1'b1, 1'b0, 8'd0, 8'd0,  8'd0,  8'd1, 8'd2,  8'd1,  2'b01, 4'd2,  4'd1},
        '{"R1 ", 3'd5, 16'd120,  1'b1, 1'b0, 8'd0, 8'd0,  8'd0,  8'd1, 8'd2,  8'd1,  2'b01, 4'd2,  4'd1},
        '{"R1 ", 3'd6, 16'd100,  1'b0, 1'b0, 8'd0, 8'd0,  8'd0,  8'd1, 8'd2,  8'd2,  2'b01, 4'd2,  4'd2},
        '{"R6 ", 3'd0, 16'd600,  1'b0, 1'b1, 8'd4, 8'd8,  8'd10, 8'd3, 8'd6,  8'd13, 2'b00, 4'd8,  4'd13},
        '{"R7 ", 3'd5, 16'd100,  1'b0, 1'b1, 8'd5, 8'd2,  8'd16, 8'd1, 8'd2,  8'd2,  2'b11, 4'd2,  4'd0},
        '{"R6 ", 3'd4, 16'd120,  1'b1, 1'b0, 8'd5, 8'd16, 8'd16, 8'd1, 8'd3,  8'd1,  2'b01, 4'd3,  4'd1}
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        mode          = v.md;
        cycle_ns      = v.cyc;
        late_rev      = v.late;
        mate_present  = v.mp;
        mate_setup    = v.msu;
        mate_active   = v.mac;
        mate_recovery = v.mrc;
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (valid) return;
        end
        check("R8", "valid timeout", 0, 1);
    endtask

    task automatic check_result(input string tag, input vec_t v);
        check(tag, "setup_cnt",      int'(setup_cnt),      int'(v.esu));
        check(tag, "active_cnt",     int'(active_cnt),     int'(v.eac));
        check(tag, "recovery_cnt",   int'(recovery_cnt),   int'(v.erc));
        check(tag, "setup_code",     int'(setup_code),     int'(v.ecode));
        check(tag, "active_field",   int'(active_field),   int'(v.eaf));
        check(tag, "recovery_field", int'(recovery_field), int'(v.erf));
    endtask

    task automatic run_one(input vec_t v);
        apply(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_valid();
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "busy", int'(busy), 0);
        check("R9", "valid", int'(valid), 0);
        check("R9", "active_cnt", int'(active_cnt), 0);
        check("R9", "setup_code", int'(setup_code), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_one(TBL[i]);
            check_result(string'(TBL[i].tag), TBL[i]);
            @(negedge clk);
            check("R8", "valid single pulse", int'(valid), 0);
        end

        // R8: busy rises after accept; start while busy is ignored
        apply(TBL[0]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8", "busy after start", int'(busy), 1);
        repeat (3) @(negedge clk);
        apply(TBL[3]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_valid();
        check_result("R8", TBL[0]);

        // R8: new request in the same cycle as a presented result
        apply(TBL[6]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R8", "valid after b2b start", int'(valid), 0);
        check("R8", "busy after b2b start", int'(busy), 1);
        check("R8", "old result held", int'(active_cnt), int'(TBL[0].eac));
        wait_valid();
        check_result("R8", TBL[6]);

        // R6: mate counts do not touch own counts
        run_one(TBL[12]);
        check("R6", "own setup kept", int'(setup_cnt), 1);
        check("R6", "own recovery kept", int'(recovery_cnt), 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule